// File: doc/BRIEF.md
# System Option and Reset Control Registers

This block keeps a small set of system control registers for a microcontroller and turns their contents into a system reset request. There are two byte-wide write ports. One is driven by the CPU when user code runs. The other is driven by the debug port. A single combinational read port returns any register.

The block holds three kinds of state:
- A protected options register. After any reset it accepts exactly one write. Its bits drive the watchdog enable, the watchdog timeout length, the stop-mode permission and the debug pin enable.
- A debug-only force-reset location. It holds no state.
- A low-voltage control register. It gates a trip input from the analog detector into a reset, and it holds a flag that records whether the last reset came from power-on or a voltage trip.

A one-cycle reset request can come from a debug force or from a gated voltage trip. The same edge that raises the request also returns every register to its reset value and re-arms the write-once lock. The host uses `sys_rst_req` to reset the rest of the chip.

The address map is fixed: 0 holds the options, 1 is the force location, 2 is the low-voltage control register, and 3 is reserved and reads 0x00. The ports are plain register strobes with no back-pressure. Every write is taken in the cycle its enable is high.

Top module: `sysctl_regs`

## Requirements
- R1: After the synchronous reset `rst_n` is released:
  - address 0 reads 0xC2;
  - address 2 reads 0x83;
  - the decoded outputs are `wdog_en`=1, `wdog_long`=1, `stop_allow`=0, `dbg_pin_en`=1.
- R2: The options register (address 0) takes only the first write after any reset, whichever port wins it. Every later write leaves it unchanged until the next reset.
- R3: Options bit layout:
  - bit 7 is `wdog_en`, bit 6 is `wdog_long`, bit 5 is `stop_allow`, bit 1 is `dbg_pin_en`;
  - bits 4 and 0 are plain storage;
  - bits 3 and 2 always read 0, so a stored value is the written byte ANDed with 0xF3.
- R4: Address 1 reads 0x00 at all times.
- R5: A CPU write to address 1 has no effect: no reset request, and no register changes.
- R6: A debug write to address 1 with bit 0 set raises `sys_rst_req` for the next cycle only. On the same edge, all registers return to their R1 values and the options lock is re-armed. A debug write to address 1 with bit 0 clear does nothing.
- R7: Address 2 layout: bit 0 is detect enable, bit 1 is reset enable, bit 2 is detect-in-stop enable, bit 7 is the read-only cause flag, and the other bits read 0. A voltage reset fires in a cycle where `lv_trip`=1 and bits 0 and 1 are both 1.
- R8: While `stop_mode`=1, a trip causes no reset unless bit 2 of address 2 is 1.
- R9: The cause flag:
  - is 1 after a power-on reset or a voltage reset;
  - is 0 after a debug-forced reset;
  - is 1 when both reset sources fire in the same cycle.
- R10: When both ports write in the same cycle, only the debug write takes effect. The CPU write is discarded in full and does not consume the options lock.
- R11: Bits 2:0 of address 2 can be rewritten at any time from either port. A write cannot change the cause flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| dbg_we | input | 1 | Debug port write strobe |
| dbg_addr | input | 2 | Debug port write address |
| dbg_wdata | input | 8 | Debug port write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| lv_trip | input | 1 | Low-voltage comparator trip |
| stop_mode | input | 1 | Chip is in stop mode |
| sys_rst_req | output | 1 | System reset request pulse |
| wdog_en | output | 1 | Watchdog enable |
| wdog_long | output | 1 | Long watchdog timeout select |
| stop_allow | output | 1 | Stop mode permitted |
| dbg_pin_en | output | 1 | Debug pin enabled |

## Verification
The bench builds the block with its default parameters: reset value 0xC2 and implemented mask 0xF3 for the options, and reset value 0x3 for the low-voltage control bits. With these values every address and every reset path can be reached with a two-bit address and a single byte of data.

Random traffic sends simultaneous writes from both ports to every address. This exercises port priority and repeated lock re-arming. The trip input is kept rare so that stretches of locked writes build up between resets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADR_OPT = 2'd0;
  localparam logic [AW-1:0] ADR_FRC = 2'd1;
  localparam logic [AW-1:0] ADR_LVD = 2'd2;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sysctl_wr_arb.sv
module sysctl_wr_arb
  import sysctl_pkg::*;
(
  input  wr_req_t cpu_req,
  input  wr_req_t dbg_req,
  output wr_req_t win_req,
  output logic    dbg_force
);
  // debug port wins outright; the losing CPU request is dropped whole
  always_comb begin
    win_req = dbg_req.we ? dbg_req : cpu_req;
    if (!win_req.we) win_req = '0;
  end

  assign dbg_force = dbg_req.we && (dbg_req.addr == ADR_FRC) && dbg_req.data[0];
endmodule

// File: rtl/sysctl_opt_reg.sv
module sysctl_opt_reg
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] OPT_RST  = 8'hC2,
  parameter logic [DW-1:0] OPT_MASK = 8'hF3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  wr_req_t       wr,
  output logic [DW-1:0] opt_q,
  output logic          locked
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      opt_q  <= OPT_RST & OPT_MASK;
      locked <= 1'b0;
    end else if (wr.we && (wr.addr == ADR_OPT) && !locked) begin
      opt_q  <= wr.data & OPT_MASK;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sysctl_lvd_ctrl.sv
module sysctl_lvd_ctrl
  import sysctl_pkg::*;
#(
  parameter logic [2:0] LVD_RST = 3'b011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  wr_req_t    wr,
  input  logic       lv_trip,
  input  logic       stop_mode,
  output logic [2:0] ctl_q,
  output logic       fire
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ctl_q <= LVD_RST;
    else if (wr.we && (wr.addr == ADR_LVD)) ctl_q <= wr.data[2:0];
  end

  // bit0 detect, bit1 reset enable, bit2 keep detecting in stop
  assign armed = ctl_q[0] && ctl_q[1] && (!stop_mode || ctl_q[2]);
  assign fire  = armed && lv_trip;
endmodule

// File: rtl/sysctl_rst_gen.sv
module sysctl_rst_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_force,
  input  logic lvd_fire,
  output logic clr,
  output logic req,
  output logic cause
);
  assign clr = dbg_force || lvd_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      cause <= 1'b1;
    end else if (clr) begin
      req   <= 1'b1;
      cause <= lvd_fire;
    end else begin
      req   <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] OPT_RST  = 8'hC2,
  parameter logic [DW-1:0] OPT_MASK = 8'hF3,
  parameter logic [2:0]    LVD_RST  = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          lv_trip,
  input  logic          stop_mode,
  output logic          sys_rst_req,
  output logic          wdog_en,
  output logic          wdog_long,
  output logic          stop_allow,
  output logic          dbg_pin_en
);
  wr_req_t       cpu_req, dbg_req, win_req;
  logic          dbg_force, lvd_fire, clr, rst_cause, opt_locked;
  logic [DW-1:0] opt_q;
  logic [2:0]    lvd_ctl;

  assign cpu_req = '{we: cpu_we, addr: cpu_addr, data: cpu_wdata};
  assign dbg_req = '{we: dbg_we, addr: dbg_addr, data: dbg_wdata};

  sysctl_wr_arb u_arb (
    .cpu_req(cpu_req), .dbg_req(dbg_req), .win_req(win_req), .dbg_force(dbg_force)
  );

  sysctl_opt_reg #(.OPT_RST(OPT_RST), .OPT_MASK(OPT_MASK)) u_opt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(win_req), .opt_q(opt_q), .locked(opt_locked)
  );

  sysctl_lvd_ctrl #(.LVD_RST(LVD_RST)) u_lvd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(win_req), .lv_trip(lv_trip),
    .stop_mode(stop_mode), .ctl_q(lvd_ctl), .fire(lvd_fire)
  );

  sysctl_rst_gen u_rst (
    .clk(clk), .rst_n(rst_n), .dbg_force(dbg_force), .lvd_fire(lvd_fire),
    .clr(clr), .req(sys_rst_req), .cause(rst_cause)
  );

  always_comb begin
    unique case (rd_addr)
      ADR_OPT: rd_data = opt_q;
      ADR_LVD: rd_data = {rst_cause, 4'b0000, lvd_ctl};
      default: rd_data = '0;
    endcase
  end

  assign wdog_en    = opt_q[7];
  assign wdog_long  = opt_q[6];
  assign stop_allow = opt_q[5];
  assign dbg_pin_en = opt_q[1];
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter logic [7:0] OPT_RST  = 8'hC2,
  parameter logic [7:0] OPT_MASK = 8'hF3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_we,
  input logic [1:0] cpu_addr,
  input logic       dbg_we,
  input logic [1:0] dbg_addr,
  input logic [7:0] dbg_wdata,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       stop_mode,
  input logic       sys_rst_req,
  input logic [7:0] opt_q,
  input logic       opt_locked,
  input logic [2:0] lvd_ctl,
  input logic       lvd_fire,
  input logic       rst_cause
);
  logic frc;
  assign frc = dbg_we && (dbg_addr == 2'd1) && dbg_wdata[0];

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (opt_q == (OPT_RST & OPT_MASK)) && !opt_locked);
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_locked && !frc && !lvd_fire) |=> $stable(opt_q));
  p_unimpl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[3:2] == 2'b00));
  p_force_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data == 8'h00));
  p_cpu_no_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 2'd1 && !frc && !lvd_fire) |=> !sys_rst_req);
  p_force_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> sys_rst_req);
  p_req_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc && !lvd_fire) |=> !sys_rst_req);
  p_lvd_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_fire |=> sys_rst_req);
  p_stop_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !lvd_ctl[2]) |-> !lvd_fire);
  p_cause_lvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_fire |=> rst_cause);
  p_cause_dbg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frc && !lvd_fire) |=> !rst_cause);
endmodule

bind sysctl_regs sysctl_regs_chk #(.OPT_RST(OPT_RST), .OPT_MASK(OPT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .dbg_we(dbg_we),
  .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
  .stop_mode(stop_mode), .sys_rst_req(sys_rst_req), .opt_q(opt_q),
  .opt_locked(opt_locked), .lvd_ctl(lvd_ctl), .lvd_fire(lvd_fire), .rst_cause(rst_cause)
);

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0, dbg_we = 1'b0, lv_trip = 1'b0, stop_mode = 1'b0;
  logic [1:0] cpu_addr = '0, dbg_addr = '0, rd_addr = '0;
  logic [7:0] cpu_wdata = '0, dbg_wdata = '0;
  logic [7:0] rd_data;
  logic       sys_rst_req, wdog_en, wdog_long, stop_allow, dbg_pin_en;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_opt;
  logic       m_lock, m_cause, m_req;
  logic [2:0] m_lvd;

  always #2.5 clk = ~clk;

  sysctl_regs dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .lv_trip(lv_trip), .stop_mode(stop_mode), .sys_rst_req(sys_rst_req),
    .wdog_en(wdog_en), .wdog_long(wdog_long), .stop_allow(stop_allow), .dbg_pin_en(dbg_pin_en)
  );

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return m_opt;
      2'd2:    return {m_cause, 4'b0000, m_lvd};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset(logic cause);
    m_opt = 8'hC2; m_lock = 1'b0; m_lvd = 3'b011; m_cause = cause;
  endtask

  task automatic model_step();
    logic frc, lvf, we;
    logic [1:0] a;
    logic [7:0] d;
    frc = dbg_we && dbg_addr == 2'd1 && dbg_wdata[0];
    lvf = lv_trip && m_lvd[0] && m_lvd[1] && (!stop_mode || m_lvd[2]);
    if (frc || lvf) begin
      model_reset(lvf);
      m_req = 1'b1;
    end else begin
      m_req = 1'b0;
      we = dbg_we || cpu_we;
      a  = dbg_we ? dbg_addr : cpu_addr;
      d  = dbg_we ? dbg_wdata : cpu_wdata;
      if (we && a == 2'd0 && !m_lock) begin m_opt = d & 8'hF3; m_lock = 1'b1; end
      if (we && a == 2'd2) m_lvd = d[2:0];
    end
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic cwe, logic [1:0] ca, logic [7:0] cd,
                      logic dwe, logic [1:0] da, logic [7:0] dd,
                      logic trip, logic stp, logic [1:0] ra);
    @(negedge clk);
    cpu_we = cwe; cpu_addr = ca; cpu_wdata = cd;
    dbg_we = dwe; dbg_addr = da; dbg_wdata = dd;
    lv_trip = trip; stop_mode = stp; rd_addr = ra;
    model_step();
    @(posedge clk); #1;
    check({tag, " read"}, rd_data, exp_read(ra));
    check({tag, " req"}, {7'b0, sys_rst_req}, {7'b0, m_req});
    check({tag, " outs"}, {4'b0, wdog_en, wdog_long, stop_allow, dbg_pin_en},
          {4'b0, m_opt[7], m_opt[6], m_opt[5], m_opt[1]});
  endtask

  task automatic idle(string tag, logic [1:0] ra);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset(1'b1); m_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    idle("R1 opt", 2'd0);
    idle("R1 lvd", 2'd2);
    // R3 masking, R2 first write honoured then locked
    step("R3 mask", 1, 0, 8'hFF, 0, 0, 0, 0, 0, 2'd0);
    step("R2 locked", 1, 0, 8'h00, 0, 0, 0, 0, 0, 2'd0);
    step("R2 dbg locked", 0, 0, 0, 1, 0, 8'h00, 0, 0, 2'd0);
    // R4, R5
    idle("R4 force read", 2'd1);
    step("R5 cpu force", 1, 1, 8'hFF, 0, 0, 0, 0, 0, 2'd0);
    idle("R5 after", 2'd0);
    // R6 debug forced reset, R9 cause cleared
    step("R6 no bit0", 0, 0, 0, 1, 1, 8'hFE, 0, 0, 2'd0);
    step("R6 force", 0, 0, 0, 1, 1, 8'h01, 0, 0, 2'd0);
    idle("R6 pulse end", 2'd2);
    idle("R9 dbg cause", 2'd2);
    step("R6 rearm", 1, 0, 8'h20, 0, 0, 0, 0, 0, 2'd0);
    // R11 lvd register from both ports
    step("R11 cpu", 1, 2, 8'hF0, 0, 0, 0, 0, 0, 2'd2);
    step("R11 dbg", 0, 0, 0, 1, 2, 8'h07, 0, 0, 2'd2);
    // R8 stop gating
    step("R8 setup", 1, 2, 8'h03, 0, 0, 0, 0, 0, 2'd2);
    step("R8 masked", 0, 0, 0, 0, 0, 0, 1, 1, 2'd0);
    step("R8 stop en", 1, 2, 8'h07, 0, 0, 0, 0, 0, 2'd2);
    step("R8 fires", 0, 0, 0, 0, 0, 0, 1, 1, 2'd0);
    idle("R9 lvd cause", 2'd2);
    // R7 gating by enables
    step("R7 setup", 1, 2, 8'h01, 0, 0, 0, 0, 0, 2'd2);
    step("R7 no rsten", 0, 0, 0, 0, 0, 0, 1, 0, 2'd0);
    step("R7 setup2", 1, 2, 8'h03, 0, 0, 0, 0, 0, 2'd2);
    step("R7 fires", 0, 0, 0, 0, 0, 0, 1, 0, 2'd2);
    // R10 port priority
    step("R10 split", 1, 0, 8'h10, 1, 2, 8'h03, 0, 0, 2'd0);
    step("R10 cpu free", 1, 0, 8'h30, 0, 0, 0, 0, 0, 2'd0);
    step("R10 force", 0, 0, 0, 1, 1, 8'h01, 0, 0, 2'd0);
    step("R10 same addr", 1, 0, 8'hF0, 1, 0, 8'h01, 0, 0, 2'd0);
    // R9 both sources at once
    step("R9 both", 0, 0, 0, 1, 1, 8'h01, 1, 0, 2'd2);
    idle("R9 both cause", 2'd2);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step("RND", 1'($urandom), 2'($urandom), 8'($urandom),
           1'($urandom), 2'($urandom), 8'($urandom),
           ($urandom % 16) == 0, 1'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule